// File: doc/BRIEF.md
# Rate-Matched Circular Transfer FIFO

This block carries data words from a slow, free-running write clock domain into a faster read clock domain. The storage is a small circular array. The write side stores one word on every write clock cycle and never stalls. The read side runs on the fast clock, but it moves only on cycles where a qualify enable is high. External logic spaces those enable pulses so that, over time, reads happen at the same average rate as writes. Individual read intervals may still be uneven.

Neither side uses a full or empty flag. Each pointer comes out of reset at a fixed distance from the other, so words can be read straight away without the two pointers colliding. The two clock sources may differ by one or two percent, so that distance drifts slowly. A tracking circuit outside this block measures the drift and corrects it by asking the read side either to skip one extra entry (slip) or to stay on the same entry for one read (hold).

A single asynchronous active-low reset is synchronised separately into each clock domain before it is released.

Top module: `rate_match_fifo`

## Requirements
- R1: After reset the write pointer starts at entry 0. On every write clock cycle it stores `wr_data` in the entry it points to and then moves to the next entry. After entry DEPTH-1 it wraps to entry 0. DEPTH defaults to 8 and must be a power of two.
- R2: On a read clock cycle with `rd_qual` high, where `rd_slip` and `rd_hold` are not both high and not exactly one of them is high, the read pointer moves forward one entry. On a cycle with `rd_qual` low, the read pointer, `rd_data` and the stored words seen by later reads do not change.
- R3: On a qualified cycle, the word at the current read pointer is loaded into `rd_data`. It appears one read clock cycle later. `rd_valid` is high in exactly the cycle after each qualified cycle and low otherwise.
- R4: The read pointer leaves reset at entry DEPTH-INIT_GAP, which is entry 4 by default. Each read therefore returns the word written INIT_GAP writes earlier than the write now due in that entry.
- R5: A qualified cycle with `rd_slip` high and `rd_hold` low reads the current entry and moves the read pointer forward by two entries.
- R6: A qualified cycle with `rd_hold` high and `rd_slip` low reads the current entry and leaves the read pointer unchanged. The next qualified read returns the same entry again.
- R7: A qualified cycle with both `rd_slip` and `rd_hold` high behaves exactly like a plain qualified read.
- R8: `rd_slip` and `rd_hold` have no effect on a cycle where `rd_qual` is low.
- R9: While `rst_n` is low, `rd_data` is 0 and `rd_valid` is 0. They take these values as soon as `rst_n` falls, without waiting for a clock edge.
- R10: Each domain leaves reset on its own clock. The first write and the first qualified read that takes effect happen on the third edge of that domain's clock after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Slow, free-running write clock |
| wr_data | input | WIDTH | Word stored on every write clock cycle |
| rd_clk | input | 1 | Fast read clock |
| rd_qual | input | 1 | High on read clock cycles where a read takes place |
| rd_slip | input | 1 | Skip one extra entry on this qualified read |
| rd_hold | input | 1 | Keep the read pointer on this qualified read |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | High in the cycle after a qualified read |

## Verification
Two pairs of controls can land in the same read cycle. The first pair is the slip and hold requests together. The second pair is a correction request together with a cycle on which the qualify enable is low. The stimulus table drives both combinations, with reads spaced irregularly between them. The bench keeps its own record of which word was written into each entry and of where the read pointer should be. Every later `rd_data` value is compared with that record, so a step that was applied wrongly shows up as the wrong word on the next read.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

  // Distance the read pointer moves on one qualified cycle.
  typedef enum logic [1:0] {
    STEP_STAY = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } rmf_step_e;

  // Slip and hold cancel each other; either one alone changes the step.
  function automatic rmf_step_e rmf_step_of(input logic slip, input logic hold);
    if (slip && !hold) begin
      return STEP_TWO;
    end else if (hold && !slip) begin
      return STEP_STAY;
    end
    return STEP_ONE;
  endfunction

endpackage

// File: rtl/rmf_rst_sync.sv
module rmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rmf_wr_side.sv
module rmf_wr_side #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] store
);

  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0]    wr_ptr_q;
  logic [PW-1:0]    wr_ptr_d;
  logic [DEPTH-1:0] wr_sel;
  logic [WIDTH-1:0] cell_q [DEPTH];

  // Free-running write pointer.
  always_comb begin
    wr_ptr_d = wr_ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
    end
  end

  // One select line per entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wr_sel[g] = (wr_ptr_q == PW'(g));
    assign store[g]  = cell_q[g];
  end

  // Storage cells carry no reset; a write happens only once out of reset.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst_n && wr_sel[i]) begin
        cell_q[i] <= wr_data;
      end
    end
  end

  p_wr_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ptr_q == $past(wr_ptr_q) + PW'(1));

  p_wr_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> store[$past(wr_ptr_q)] == $past(wr_data));

endmodule

// File: rtl/rmf_rd_side.sv
module rmf_rd_side
  import rmf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int WIDTH    = 16,
  parameter int INIT_GAP = DEPTH / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0][WIDTH-1:0] store,
  input  logic                        rd_qual,
  input  logic                        rd_slip,
  input  logic                        rd_hold,
  output logic [WIDTH-1:0]            rd_data,
  output logic                        rd_valid
);

  localparam int            PW       = $clog2(DEPTH);
  localparam logic [PW-1:0] RD_RESET = PW'(DEPTH - INIT_GAP);

  rmf_step_e        step;
  logic [PW-1:0]    rd_ptr_q;
  logic [PW-1:0]    rd_ptr_d;
  logic [WIDTH-1:0] rd_data_q;
  logic [WIDTH-1:0] rd_data_d;
  logic             rd_valid_q;
  logic             rd_valid_d;
  logic [WIDTH-1:0] entry_sel;

  assign entry_sel = store[rd_ptr_q];

  // Next-state: pointer step, captured word and valid strobe.
  always_comb begin
    step       = rmf_step_of(rd_slip, rd_hold);
    rd_ptr_d   = rd_ptr_q;
    rd_data_d  = rd_data_q;
    rd_valid_d = 1'b0;
    if (rd_qual) begin
      rd_data_d  = entry_sel;
      rd_valid_d = 1'b1;
      case (step)
        STEP_STAY: rd_ptr_d = rd_ptr_q;
        STEP_TWO:  rd_ptr_d = rd_ptr_q + PW'(2);
        default:   rd_ptr_d = rd_ptr_q + PW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q   <= RD_RESET;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_ptr_q   <= rd_ptr_d;
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  p_idle_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_qual |=> $stable(rd_ptr_q) && $stable(rd_data_q) && !rd_valid_q);

  p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_qual && !rd_slip && !rd_hold |=> rd_ptr_q == $past(rd_ptr_q) + PW'(1));

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_qual |=> rd_valid_q);

  p_slip_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_qual && rd_slip && !rd_hold |=> rd_ptr_q == $past(rd_ptr_q) + PW'(2));

  p_hold_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_qual && rd_hold && !rd_slip |=> $stable(rd_ptr_q));

  p_both_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_qual && rd_slip && rd_hold |=> rd_ptr_q == $past(rd_ptr_q) + PW'(1));

endmodule

// File: rtl/rate_match_fifo.sv
module rate_match_fifo #(
  parameter int DEPTH       = 8,
  parameter int WIDTH       = 16,
  parameter int INIT_GAP    = DEPTH / 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             wr_clk,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_qual,
  input  logic             rd_slip,
  input  logic             rd_hold,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  logic                        wr_rst_n;
  logic                        rd_rst_n;
  logic [DEPTH-1:0][WIDTH-1:0] store;

  rmf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk    (wr_clk),
    .arst_n (rst_n),
    .srst_n (wr_rst_n)
  );

  rmf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk    (rd_clk),
    .arst_n (rst_n),
    .srst_n (rd_rst_n)
  );

  rmf_wr_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
    .clk     (wr_clk),
    .rst_n   (wr_rst_n),
    .wr_data (wr_data),
    .store   (store)
  );

  rmf_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .INIT_GAP(INIT_GAP)) u_rd (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .store    (store),
    .rd_qual  (rd_qual),
    .rd_slip  (rd_slip),
    .rd_hold  (rd_hold),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: tb/rate_match_fifo_bench.sv
`timescale 1ns/1ps
module rate_match_fifo_bench;

  localparam int WIDTH = 16;
  localparam int DEPTH = 8;
  localparam int GAP   = 4;

  // Vector fields: {qual, slip, hold, step[1:0]}
  localparam logic [4:0] VQ  = 5'b10001;
  localparam logic [4:0] VI  = 5'b00000;
  localparam logic [4:0] VQS = 5'b11010;
  localparam logic [4:0] VQH = 5'b10100;
  localparam logic [4:0] VQB = 5'b11101;
  localparam logic [4:0] VIS = 5'b01000;
  localparam logic [4:0] VIH = 5'b00100;
  localparam logic [4:0] VIB = 5'b01100;
  localparam int NVEC = 48;
  localparam logic [4:0] VEC [NVEC] = '{
    VQ, VI,  VQ, VI,  VQ, VQ,  VI, VI,  VQ, VI,  VI, VQ,
    VQ, VI,  VQH, VI, VQ, VI,  VQ, VIS, VQ, VI,  VQS, VI,
    VQ, VIH, VQ, VI,  VQB, VI, VQ, VI,  VQ, VQ,  VI, VI,
    VQH, VI, VQ, VIB, VQS, VI, VQ, VI,  VI, VQ,  VQ, VI
  };

  logic             rst_n, wr_clk, rd_clk, rd_qual, rd_slip, rd_hold, rd_valid;
  logic [WIDTH-1:0] wr_data, rd_data;
  logic [1:0]       cur_step;
  int               checks, fails, wr_seq;
  bit               done;

  rate_match_fifo u_rate_match_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data), .rd_clk(rd_clk),
    .rd_qual(rd_qual), .rd_slip(rd_slip), .rd_hold(rd_hold),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  initial begin rd_clk = 0; forever #2.5 rd_clk = ~rd_clk; end
  initial begin wr_clk = 0; #1.25; forever #5 wr_clk = ~wr_clk; end

  initial begin wr_data = '0; wr_seq = 0; end
  always @(negedge wr_clk) begin
    wr_seq++;
    wr_data = WIDTH'(16'h5A00 + wr_seq);
  end

  // Reference model built from the requirements.
  logic [WIDTH-1:0] mdl [DEPTH];
  bit               mknown [DEPTH];
  int               wp, rp, wr_edges, rd_edges;
  logic [WIDTH-1:0] exp_data;
  bit               exp_known, exp_valid;

  always @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_edges = 0; wp = 0;
      for (int i = 0; i < DEPTH; i++) mknown[i] = 0;
    end else begin
      wr_edges++;
      if (wr_edges >= 3) begin
        mdl[wp] = wr_data; mknown[wp] = 1; wp = (wp + 1) % DEPTH;
      end
    end
  end

  always @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_edges = 0; rp = DEPTH - GAP; exp_valid = 0; exp_known = 1; exp_data = '0;
    end else begin
      rd_edges++;
      if (rd_edges >= 3 && rd_qual) begin
        exp_data = mdl[rp]; exp_known = mknown[rp]; exp_valid = 1;
        rp = (rp + int'(cur_step)) % DEPTH;
      end else begin
        exp_valid = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string vtag(input logic [4:0] v);
    if (v[4] && v[3] && v[2]) return "R7";
    if (v[4] && v[3]) return "R5";
    if (v[4] && v[2]) return "R6";
    if (!v[4] && (v[3] || v[2])) return "R8";
    return "R2";
  endfunction

  initial begin
    #500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    string last_tag, data_tag;
    bit    first_known;
    checks = 0; fails = 0; done = 0;
    rst_n = 0; rd_qual = 1; rd_slip = 1; rd_hold = 0; cur_step = 2'd1;
    // R9: outputs held at zero during reset despite active controls
    repeat (3) @(negedge rd_clk);
    chk("R9 reset rd_valid", WIDTH'(rd_valid), '0);
    chk("R9 reset rd_data", rd_data, '0);
    rd_qual = 0; rd_slip = 0;
    #1 rst_n = 1;
    wait (wr_edges >= 3);
    @(negedge rd_clk);
    last_tag = "R2"; first_known = 1;
    // Table walk: two passes, irregular read spacing with corrections.
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < NVEC; k++) begin
        rd_qual = VEC[k][4]; rd_slip = VEC[k][3]; rd_hold = VEC[k][2]; cur_step = VEC[k][1:0];
        data_tag = last_tag;
        if (VEC[k][4] || VEC[k][3] || VEC[k][2]) last_tag = vtag(VEC[k]);
        @(negedge rd_clk);
        chk("R3 rd_valid", WIDTH'(rd_valid), WIDTH'(exp_valid));
        if (exp_known) begin
          if (exp_valid && first_known && pass == 0 && k > 20) begin
            chk("R4 first tracked word R1", rd_data, exp_data);
            first_known = 0;
          end else if (exp_valid) begin
            chk({data_tag, " read word R1"}, rd_data, exp_data);
          end else begin
            chk("R2 idle keeps rd_data", rd_data, exp_data);
          end
        end
      end
    end
    // R10: reads take effect from the third read edge after release.
    rd_qual = 0; rd_slip = 0; rd_hold = 0; cur_step = 2'd1;
    @(negedge rd_clk) rst_n = 0;
    repeat (2) @(negedge rd_clk);
    rst_n = 1; rd_qual = 1;
    @(negedge rd_clk); chk("R10 edge1 rd_valid", WIDTH'(rd_valid), '0);
    @(negedge rd_clk); chk("R10 edge2 rd_valid", WIDTH'(rd_valid), '0);
    @(negedge rd_clk); chk("R10 edge3 rd_valid", WIDTH'(rd_valid), WIDTH'(1));
    // R9: asynchronous assertion clears outputs before any edge.
    @(negedge rd_clk);
    #1 rst_n = 0;
    #0.5;
    chk("R9 async rd_valid", WIDTH'(rd_valid), '0);
    chk("R9 async rd_data", rd_data, '0);
    rd_qual = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule